// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a processor's trap logic and decides, in the same cycle that a trap is raised, where the trap goes. A breakpoint trap can be captured into debug mode, depending on which privilege level the hart was running at and whether the breakpoint-capture enable for that level is set. Once the hart is in debug mode, any further trap is steered to one of two fixed debug ROM addresses. Every trap the block does not claim is flagged back to the core, so that the normal trap handler can take it.

The block holds three pieces of debug state: a debug control/status word, the saved debug PC and a debug scratch word. These are reached through a small select-based CSR port. The read data is combinational from the current state, and writes take effect at the clock edge. A non-zero cause field means the hart is in debug mode. The cause field only leaves debug mode through a reset.

There are two resets. A cold reset holds `por_n` and `rst_n` low together, and it loads the halt bit from `halt_on_boot_i`. A warm reset holds only `rst_n` low, and it always clears the halt bit.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After a cold reset the state is as follows. The cause field is 0, the recorded privilege is 3, and step and all breakpoint enables are 0. The saved PC and the scratch word are 0. The halt bit (bit 3) equals `halt_on_boot_i`.
- R2: A warm reset that follows the first cold reset clears the halt bit, whatever the value of `halt_on_boot_i`. It restores the same values as R1 for all other state.
- R3: Outside debug mode, a trap whose code equals BRK_CODE (default 3) is taken into debug mode when the enable bit for the raw `cur_prv_i` is set. The enable bits are bit 12 for U=0, bit 13 for S=1, bit 14 for H=2 and bit 15 for M=3. In that same cycle the block asserts `redir_valid_o` with `redir_pc_o` = ENTRY_ADDR, and asserts `prv_force_valid_o` with `prv_force_o` = 3.
- R4: On entry to debug mode, the cause field (bits 8:6) becomes 1, meaning software breakpoint. The recorded privilege (bits 1:0) takes the prior privilege, with H mapped to U. The saved PC takes `trap_pc_i`.
- R5: Outside debug mode, a trap that is not captured raises `trap_pass_o` and no redirect, and it changes no state.
- R6: With the cause field non-zero, a breakpoint trap redirects to ENTRY_ADDR and any other trap redirects to EXC_ADDR. In both cases `prv_force_valid_o` and `trap_pass_o` stay 0 and no state changes.
- R7: A control-word write (select 0) updates these fields: recorded privilege at bits 1:0, step at bit 2, halt at bit 3, and the four breakpoint enables at bits 15:12. The cause field is not writable.
- R8: The control word always reads with bits 31:30 equal to 1. Bits 29, 28, 10 and 9 read as 0. Bit 5 follows `dbg_irq_i`.
- R9: A privilege value of 2 (H) written to the control word is stored and read back as 0 (U).
- R10: Select 1 reads and writes the saved PC and select 2 reads and writes the scratch word. Select 3 reads 0 and ignores writes.
- R11: When a debug-mode entry and a CSR write to the saved PC or the control word fall in the same cycle, the entry values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low (warm) |
| por_n | input | 1 | Cold-reset qualifier, held low with rst_n on the first reset |
| halt_on_boot_i | input | 1 | Halt value loaded on cold reset |
| dbg_irq_i | input | 1 | External debug interrupt, reflected in the control word |
| trap_valid_i | input | 1 | A trap is raised this cycle |
| trap_code_i | input | CODE_W | Trap cause code |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| cur_prv_i | input | 2 | Current privilege level |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 2 | CSR select: 0 control, 1 saved PC, 2 scratch |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for the selected register |
| redir_valid_o | output | 1 | The block redirects the PC this cycle |
| redir_pc_o | output | XLEN | Redirect target |
| prv_force_valid_o | output | 1 | Privilege must be forced this cycle |
| prv_force_o | output | 2 | Forced privilege level |
| trap_pass_o | output | 1 | The trap goes to the normal handler |

## Verification
The assertions check the following on every cycle:
- The redirect and pass flags are never both set.
- Every entry leaves the cause at 1, the saved PC equal to the trapping PC, and a recorded privilege other than H.
- A non-zero cause stays unchanged until a reset.
- A trap taken inside debug mode leaves the saved PC untouched.

Only the bench scenarios can show the following:
- The per-privilege choice of the enable bit.
- The split between the entry and exception addresses.
- That the halt-on-boot value is honoured only on the first reset.
- The field masking of control-word writes.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

   typedef enum logic [2:0] {
      DCAUSE_NONE   = 3'd0,
      DCAUSE_SWBP   = 3'd1,
      DCAUSE_TRIG   = 3'd2,
      DCAUSE_DBGINT = 3'd3,
      DCAUSE_STEP   = 3'd4,
      DCAUSE_HALT   = 3'd5
   } dcause_e;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DPC  = 2'd1,
      SEL_SCR  = 2'd2,
      SEL_NONE = 2'd3
   } dsel_e;

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_H = 2'd2;
   localparam logic [1:0] PRV_M = 2'd3;

   // control word field positions
   localparam int CW_PRV_LO  = 0;
   localparam int CW_STEP    = 2;
   localparam int CW_HALT    = 3;
   localparam int CW_DBGINT  = 5;
   localparam int CW_CAUSE_LO = 6;
   localparam int CW_EBK_LO  = 12;
   localparam int CW_VER_LO  = 30;

   function automatic logic [1:0] fold_prv(input logic [1:0] p);
      return (p == PRV_H) ? PRV_U : p;
   endfunction

endpackage

// File: rtl/dbg_boot_arm.sv
module dbg_boot_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic por_n,
   output logic boot_o
);
   logic armed_q;

   // armed by the cold reset, disarmed by the first cycle out of reset
   always_ff @(posedge clk) begin
      if (!por_n)     armed_q <= 1'b1;
      else if (rst_n) armed_q <= 1'b0;
   end

   assign boot_o = armed_q | ~por_n;
endmodule

// File: rtl/dbg_entry_decide.sv
module dbg_entry_decide
   import dbg_entry_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          CODE_W     = 4,
   parameter int unsigned BRK_CODE   = 3,
   parameter int unsigned ENTRY_ADDR = 32'h0000_0800,
   parameter int unsigned EXC_ADDR   = 32'h0000_0808
) (
   input  logic              trap_valid_i,
   input  logic [CODE_W-1:0] trap_code_i,
   input  logic [1:0]        cur_prv_i,
   input  logic              in_debug_i,
   input  logic [3:0]        ebk_en_i,
   output logic              redir_o,
   output logic [XLEN-1:0]   redir_pc_o,
   output logic              force_o,
   output logic              pass_o,
   output logic              enter_o
);
   localparam logic [XLEN-1:0]   ENTRY_PC = XLEN'(ENTRY_ADDR);
   localparam logic [XLEN-1:0]   EXC_PC   = XLEN'(EXC_ADDR);
   localparam logic [CODE_W-1:0] BRK      = CODE_W'(BRK_CODE);

   logic is_brk;
   logic brk_enabled;

   assign is_brk      = (trap_code_i == BRK);
   assign brk_enabled = ebk_en_i[cur_prv_i];

   always_comb begin
      redir_o    = 1'b0;
      redir_pc_o = '0;
      force_o    = 1'b0;
      pass_o     = 1'b0;
      enter_o    = 1'b0;
      if (trap_valid_i) begin
         if (in_debug_i) begin
            redir_o    = 1'b1;
            redir_pc_o = is_brk ? ENTRY_PC : EXC_PC;
         end else if (is_brk && brk_enabled) begin
            redir_o    = 1'b1;
            redir_pc_o = ENTRY_PC;
            force_o    = 1'b1;
            enter_o    = 1'b1;
         end else begin
            pass_o     = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbg_csr_file.sv
module dbg_csr_file
   import dbg_entry_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter bit HAS_H = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt_init_i,
   input  logic            dbg_irq_i,
   input  logic            enter_i,
   input  logic [1:0]      enter_prv_i,
   input  logic [XLEN-1:0] enter_pc_i,
   input  logic            we_i,
   input  logic [1:0]      sel_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] rdata_o,
   output logic            in_debug_o,
   output logic [3:0]      ebk_en_o
);
   logic [2:0]      cause_q;
   logic [1:0]      prv_q;
   logic            step_q;
   logic            halt_q;
   logic [3:0]      ebk_q;
   logic [XLEN-1:0] dpc_q;
   logic [XLEN-1:0] scr_q;
   logic [3:0]      ebk_mask;
   logic [31:0]     ctrl_word;

   generate
      if (HAS_H) begin : g_with_h
         assign ebk_mask = 4'b1111;
      end else begin : g_no_h
         assign ebk_mask = 4'b1011;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= DCAUSE_NONE;
         prv_q   <= PRV_M;
         step_q  <= 1'b0;
         halt_q  <= halt_init_i;
         ebk_q   <= '0;
         dpc_q   <= '0;
         scr_q   <= '0;
      end else begin
         if (we_i && sel_i == SEL_CTRL) begin
            prv_q  <= fold_prv(wdata_i[CW_PRV_LO +: 2]);
            step_q <= wdata_i[CW_STEP];
            halt_q <= wdata_i[CW_HALT];
            ebk_q  <= wdata_i[CW_EBK_LO +: 4] & ebk_mask;
         end
         if (we_i && sel_i == SEL_DPC) dpc_q <= wdata_i;
         if (we_i && sel_i == SEL_SCR) scr_q <= wdata_i;
         // entry overrides a same-cycle software write
         if (enter_i) begin
            cause_q <= DCAUSE_SWBP;
            prv_q   <= fold_prv(enter_prv_i);
            dpc_q   <= enter_pc_i;
         end
      end
   end

   always_comb begin
      ctrl_word                       = '0;
      ctrl_word[CW_VER_LO +: 2]       = 2'd1;
      ctrl_word[CW_EBK_LO +: 4]       = ebk_q;
      ctrl_word[CW_CAUSE_LO +: 3]     = cause_q;
      ctrl_word[CW_DBGINT]            = dbg_irq_i;
      ctrl_word[CW_HALT]              = halt_q;
      ctrl_word[CW_STEP]              = step_q;
      ctrl_word[CW_PRV_LO +: 2]       = prv_q;
   end

   always_comb begin
      unique case (sel_i)
         SEL_CTRL: rdata_o = XLEN'(ctrl_word);
         SEL_DPC:  rdata_o = dpc_q;
         SEL_SCR:  rdata_o = scr_q;
         default:  rdata_o = '0;
      endcase
   end

   assign in_debug_o = (cause_q != DCAUSE_NONE);
   assign ebk_en_o   = ebk_q;

   AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> cause_q == DCAUSE_SWBP) else $error("entry cause"); // R4
   AST_ENTRY_DPC: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> dpc_q == $past(enter_pc_i)) else $error("entry dpc"); // R11
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q != DCAUSE_NONE) |=> $stable(cause_q)) else $error("cause sticky"); // R6
   AST_PRV_NOT_H: assert property (@(posedge clk) disable iff (!rst_n)
      prv_q != PRV_H) else $error("prv holds H"); // R9
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
   import dbg_entry_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          CODE_W     = 4,
   parameter int unsigned BRK_CODE   = 3,
   parameter int unsigned ENTRY_ADDR = 32'h0000_0800,
   parameter int unsigned EXC_ADDR   = 32'h0000_0808,
   parameter bit          HAS_H      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              halt_on_boot_i,
   input  logic              dbg_irq_i,
   input  logic              trap_valid_i,
   input  logic [CODE_W-1:0] trap_code_i,
   input  logic [XLEN-1:0]   trap_pc_i,
   input  logic [1:0]        cur_prv_i,
   input  logic              csr_we_i,
   input  logic [1:0]        csr_sel_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   output logic [XLEN-1:0]   csr_rdata_o,
   output logic              redir_valid_o,
   output logic [XLEN-1:0]   redir_pc_o,
   output logic              prv_force_valid_o,
   output logic [1:0]        prv_force_o,
   output logic              trap_pass_o
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("XLEN must be at least 32");
      end
      if (CODE_W < 1 || BRK_CODE >= (1 << CODE_W)) begin : g_bad_code
         $error("BRK_CODE does not fit CODE_W");
      end
      if (ENTRY_ADDR == EXC_ADDR) begin : g_bad_addr
         $error("entry and exception addresses must differ");
      end
   endgenerate

   logic       boot;
   logic       in_debug;
   logic [3:0] ebk_en;
   logic       enter;

   dbg_boot_arm u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .por_n  (por_n),
      .boot_o (boot)
   );

   dbg_entry_decide #(
      .XLEN       (XLEN),
      .CODE_W     (CODE_W),
      .BRK_CODE   (BRK_CODE),
      .ENTRY_ADDR (ENTRY_ADDR),
      .EXC_ADDR   (EXC_ADDR)
   ) u_decide (
      .trap_valid_i (trap_valid_i),
      .trap_code_i  (trap_code_i),
      .cur_prv_i    (cur_prv_i),
      .in_debug_i   (in_debug),
      .ebk_en_i     (ebk_en),
      .redir_o      (redir_valid_o),
      .redir_pc_o   (redir_pc_o),
      .force_o      (prv_force_valid_o),
      .pass_o       (trap_pass_o),
      .enter_o      (enter)
   );

   dbg_csr_file #(
      .XLEN  (XLEN),
      .HAS_H (HAS_H)
   ) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_init_i (halt_on_boot_i & boot),
      .dbg_irq_i   (dbg_irq_i),
      .enter_i     (enter),
      .enter_prv_i (cur_prv_i),
      .enter_pc_i  (trap_pc_i),
      .we_i        (csr_we_i),
      .sel_i       (csr_sel_i),
      .wdata_i     (csr_wdata_i),
      .rdata_o     (csr_rdata_o),
      .in_debug_o  (in_debug),
      .ebk_en_o    (ebk_en)
   );

   assign prv_force_o = prv_force_valid_o ? PRV_M : PRV_U;

   AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({redir_valid_o, trap_pass_o})) else $error("two routes"); // R5
   AST_NO_TRAP_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid_i |-> !redir_valid_o && !trap_pass_o) else $error("route without trap"); // R3
   AST_DEBUG_KEEPS_DPC: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i && in_debug && !csr_we_i |=> $stable(u_csr.dpc_q)) else $error("dpc moved"); // R6
endmodule

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
   localparam int XLEN = 32;
   localparam int CW   = 4;
   localparam logic [31:0] ENT = 32'h0000_0800;
   localparam logic [31:0] EXC = 32'h0000_0808;

   logic clk = 1'b0;
   logic rst_n = 1'b0, por_n = 1'b0, halt_cfg = 1'b1, irq = 1'b0;
   logic tv = 1'b0;
   logic [CW-1:0] code = '0;
   logic [XLEN-1:0] pc = '0;
   logic [1:0] prv = 2'd3;
   logic we = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [XLEN-1:0] wd = '0;
   logic [XLEN-1:0] rd, rpc;
   logic rv, fv, pass;
   logic [1:0] fprv;

   int n_cmp = 0, n_bad = 0;

   // model state
   logic [2:0] m_cause; logic [1:0] m_prv; logic m_step, m_halt;
   logic [3:0] m_ebk; logic [31:0] m_dpc, m_scr;

   always #5 clk = ~clk;

   dbg_entry_ctrl u_dbg_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .halt_on_boot_i(halt_cfg),
      .dbg_irq_i(irq), .trap_valid_i(tv), .trap_code_i(code), .trap_pc_i(pc),
      .cur_prv_i(prv), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wd),
      .csr_rdata_o(rd), .redir_valid_o(rv), .redir_pc_o(rpc),
      .prv_force_valid_o(fv), .prv_force_o(fprv), .trap_pass_o(pass)
   );

   function automatic logic [31:0] exp_ctrl();
      logic [31:0] v = '0;
      v[31:30] = 2'd1; v[15:12] = m_ebk; v[8:6] = m_cause; v[5] = irq;
      v[3] = m_halt; v[2] = m_step; v[1:0] = m_prv;
      return v;
   endfunction

   function automatic logic [1:0] fold(input logic [1:0] p);
      return (p == 2'd2) ? 2'd0 : p;
   endfunction

   task automatic model_reset(input logic hv);
      m_cause = 0; m_prv = 2'd3; m_step = 0; m_halt = hv;
      m_ebk = 0; m_dpc = 0; m_scr = 0;
   endtask

   // one cycle: drive, check combinational outputs, update model at the edge
   task automatic cyc(input logic t, input logic [CW-1:0] c, input logic [31:0] p,
                      input logic [1:0] pr, input logic w, input logic [1:0] s,
                      input logic [31:0] d, input string tag);
      logic e_rv, e_fv, e_pass, brk, enter;
      logic [31:0] e_pc, e_rd;
      logic [1:0] e_fp;
      @(negedge clk);
      tv = t; code = c; pc = p; prv = pr; we = w; sel = s; wd = d;
      #1;
      brk = (c == CW'(3));
      e_rv = 0; e_fv = 0; e_pass = 0; e_pc = 0; enter = 0;
      if (t) begin
         if (m_cause != 0) begin e_rv = 1; e_pc = brk ? ENT : EXC; end
         else if (brk && m_ebk[pr]) begin e_rv = 1; e_pc = ENT; e_fv = 1; enter = 1; end
         else e_pass = 1;
      end
      e_fp = e_fv ? 2'd3 : 2'd0;
      case (s)
         2'd0: e_rd = exp_ctrl();
         2'd1: e_rd = m_dpc;
         2'd2: e_rd = m_scr;
         default: e_rd = 0;
      endcase
      n_cmp++;
      if (rv !== e_rv || rpc !== e_pc || fv !== e_fv || fprv !== e_fp ||
          pass !== e_pass || rd !== e_rd) begin
         n_bad++;
         $display("FAIL %s: got rv=%b pc=%h fv=%b fp=%0d pass=%b rd=%h exp rv=%b pc=%h fv=%b fp=%0d pass=%b rd=%h",
                  tag, rv, rpc, fv, fprv, pass, rd, e_rv, e_pc, e_fv, e_fp, e_pass, e_rd);
      end
      @(posedge clk);
      if (w && s == 2'd0) begin
         m_prv = fold(d[1:0]); m_step = d[2]; m_halt = d[3]; m_ebk = d[15:12];
      end
      if (w && s == 2'd1) m_dpc = d;
      if (w && s == 2'd2) m_scr = d;
      if (enter) begin m_cause = 3'd1; m_prv = fold(pr); m_dpc = p; end
   endtask

   task automatic rd_only(input logic [1:0] s, input string tag);
      cyc(0, 0, 0, 2'd3, 0, s, 0, tag);
   endtask

   task automatic warm_reset();
      @(negedge clk); rst_n = 0; tv = 0; we = 0;
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1;
      model_reset(1'b0);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; por_n = 1;
      model_reset(1'b1);
      // R1 cold reset state, halt loaded
      rd_only(2'd0, "R1"); rd_only(2'd1, "R1"); rd_only(2'd2, "R1");
      // R2 warm reset clears halt even with config set
      warm_reset();
      rd_only(2'd0, "R2");
      // R8 constant fields and interrupt mirror
      irq = 1; rd_only(2'd0, "R8"); irq = 0;
      // R7 write all ones: cause must stay 0
      cyc(0, 0, 0, 3, 1, 2'd0, 32'hFFFF_FFFF, "R7");
      rd_only(2'd0, "R7");
      // R9 privilege H written folds to U
      cyc(0, 0, 0, 3, 1, 2'd0, 32'h0000_000A, "R9");
      rd_only(2'd0, "R9");
      // R10 dpc, scratch, unused select
      cyc(0, 0, 0, 3, 1, 2'd1, 32'h1234_5678, "R10");
      cyc(0, 0, 0, 3, 1, 2'd2, 32'hCAFE_F00D, "R10");
      cyc(0, 0, 0, 3, 1, 2'd3, 32'hDEAD_BEEF, "R10");
      rd_only(2'd1, "R10"); rd_only(2'd2, "R10"); rd_only(2'd3, "R10");
      // R5 breakpoint in U with only M enabled passes; other codes pass
      cyc(0, 0, 0, 3, 1, 2'd0, 32'h0000_8000, "R7");
      cyc(1, 4'd3, 32'h100, 2'd0, 0, 2'd1, 0, "R5");
      cyc(1, 4'd7, 32'h104, 2'd3, 0, 2'd1, 0, "R5");
      rd_only(2'd0, "R5");
      // R3 breakpoint in S with S enabled enters
      cyc(0, 0, 0, 3, 1, 2'd0, 32'h0000_2000, "R7");
      cyc(1, 4'd3, 32'h0000_4440, 2'd1, 0, 2'd0, 0, "R3");
      rd_only(2'd0, "R4"); rd_only(2'd1, "R4");
      // R6 traps inside debug mode
      cyc(1, 4'd3, 32'h0000_9990, 2'd3, 0, 2'd1, 0, "R6");
      cyc(1, 4'd2, 32'h0000_9994, 2'd3, 0, 2'd1, 0, "R6");
      rd_only(2'd0, "R6"); rd_only(2'd1, "R6");
      // R11 entry with same-cycle dpc write; also H privilege entry
      warm_reset();
      cyc(0, 0, 0, 3, 1, 2'd0, 32'h0000_4000, "R7");
      cyc(1, 4'd3, 32'h0000_7770, 2'd2, 1, 2'd1, 32'h0000_0001, "R11");
      rd_only(2'd1, "R11"); rd_only(2'd0, "R4");
      // random phase with periodic warm resets
      for (int i = 0; i < 600; i++) begin
         logic t, w, brk;
         logic [CW-1:0] c;
         logic [1:0] pr, s;
         string tag;
         if (i % 60 == 59) warm_reset();
         irq = $urandom_range(0, 1);
         t = ($urandom_range(0, 1) == 1);
         brk = ($urandom_range(0, 9) < 4);
         c = brk ? CW'(3) : CW'($urandom_range(0, 15));
         pr = 2'($urandom_range(0, 3));
         w = ($urandom_range(0, 9) < 3);
         s = 2'($urandom_range(0, 3));
         if (!t) tag = "R10";
         else if (m_cause != 0) tag = "R6";
         else if (c == CW'(3) && m_ebk[pr]) tag = "R3";
         else tag = "R5";
         cyc(t, c, 32'($urandom) & 32'hFFFF_FFFC, pr, w, s, 32'($urandom), tag);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule